// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the software-facing register layer of a simple serial transceiver. It decodes word-aligned accesses from a memory-mapped bus into seven 32-bit registers: a status word, a data register that holds one received character, a baud-rate divisor, three control words and a guard-time word. Serialisation and baud generation sit outside the block. The block sees a received character as a one-cycle `rx_valid` strobe and gives back a `rx_ready` level.

Three status flags exist: receive-full (bit 5), transmit-done (bit 6) and transmit-idle (bit 7). The first control word has enable bits at the same three positions. The single level interrupt `irq` is high while any flag is set together with its matching enable. Because `irq` is a pure function of held state, it follows every event that changes a flag or an enable without any further bookkeeping. Software clears flags by writing a mask to the status word. Each write to the data register sets transmit-done again. Transmission is treated as instantaneous, so transmit-idle is always set.

Top module: `uart_regfront`

## Requirements
- R1: After reset, the status word reads 0x000000C0, the baud, control and guard-time words read 0, `irq` is low and `rx_ready` is high.
- R2: `irq` is high exactly when (status AND control1) has bit 5, 6 or 7 set. It takes the new value in the cycle after the access or receive that changed either operand.
- R3: An `rx_valid` strobe while `rx_ready` is high stores `rx_char` and sets status bit 5, which drops `rx_ready`. A strobe while `rx_ready` is low is ignored and the held character is kept.
- R4: A read at offset 0x04 returns the held character zero-extended and limited to its low 10 bits, and clears status bit 5.
- R5: A write at offset 0x00 ANDs the value into status bits 5 and 6 (a 0 clears the bit and a 1 keeps it). Bit 7 stays set and all other status bits read 0.
- R6: A write at offset 0x04 sets status bit 6.
- R7: Control1 at offset 0x0C is written and read back as a full 32-bit word.
- R8: The baud (0x08), control2 (0x10), control3 (0x14) and guard-time (0x18) words are written and read back as full 32-bit words.
- R9: A received character wins over a same-cycle clear. If a character is taken in the same cycle as a status write clearing bit 5, or as a data read, bit 5 ends set and the new character is held. The data read still returns the previous character.
- R10: A read at an unmapped offset returns 0, and a write there changes no register.
- R11: Read data appears on `bus_rdata` in the cycle after the read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | RX_W | Received character |
| rx_ready | output | 1 | High while a new character can be taken |
| irq | output | 1 | Level interrupt |

## Verification
A character arriving from the line can fall in the same cycle as a bus access that clears receive-full, either a status write of 0 or a data register read. The bench drives `rx_valid` and the bus access on the same falling edge. After the shared rising edge it expects `rx_ready` low and `irq` high. It then expects the status read to show bit 5 set and the data read to return the new character. In the read case it also expects the colliding read to return the older character.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
   localparam int REG_W   = 32;
   localparam int NREG    = 7;
   localparam int BIT_RXF = 5;
   localparam int BIT_TXD = 6;
   localparam int BIT_TXE = 7;
   localparam int NFLAG   = 3;
   localparam int FLAG_POS [NFLAG] = '{BIT_RXF, BIT_TXD, BIT_TXE};
   localparam logic [REG_W-1:0] STAT_RESET = 32'h0000_00C0;

   typedef enum int {
      RI_STAT  = 0,
      RI_DATA  = 1,
      RI_BAUD  = 2,
      RI_CTL1  = 3,
      RI_CTL2  = 4,
      RI_CTL3  = 5,
      RI_GUARD = 6
   } reg_idx_e;

   localparam int NCFG = 4;
   localparam int CFG_IDX [NCFG] = '{RI_BAUD, RI_CTL2, RI_CTL3, RI_GUARD};
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
   import uart_rf_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int N      = NREG
) (
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   output logic [N-1:0]      hit
);
   localparam int SPAN = N * 4;

   if ((1 << ADDR_W) < SPAN) begin : g_addr_chk
      $error("ADDR_W too narrow for register span");
   end

   for (genvar i = 0; i < N; i++) begin : g_hit
      assign hit[i] = sel && (addr == ADDR_W'(i * 4));
   end
endmodule

// File: rtl/uart_rf_status.sv
module uart_rf_status
   import uart_rf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stat_wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             data_rd,
   input  logic             data_wr,
   input  logic             rx_take,
   output logic             rxf,
   output logic             txd,
   output logic             txe
);
   logic rxf_q, txd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxf_q <= STAT_RESET[BIT_RXF];
         txd_q <= STAT_RESET[BIT_TXD];
      end else begin
         if (rx_take)
            rxf_q <= 1'b1;
         else if (data_rd || (stat_wr && !wdata[BIT_RXF]))
            rxf_q <= 1'b0;

         if (data_wr)
            txd_q <= 1'b1;
         else if (stat_wr && !wdata[BIT_TXD])
            txd_q <= 1'b0;
      end
   end

   assign rxf = rxf_q;
   assign txd = txd_q;
   assign txe = 1'b1;

   // R6
   txd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> txd);

   // R3
   rxf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_take |=> rxf);

   // R4
   rxf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !rx_take) |=> !rxf);

   // R9
   rx_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_take && stat_wr && !wdata[BIT_RXF]) |=> rxf);

   // R5
   keep_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wdata[BIT_TXD] && txd) |=> txd);
endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq
   import uart_rf_pkg::*;
(
   input  logic [REG_W-1:0] stat,
   input  logic [REG_W-1:0] ctl1,
   output logic             irq
);
   logic [NFLAG-1:0] hot;

   for (genvar k = 0; k < NFLAG; k++) begin : g_src
      assign hot[k] = stat[FLAG_POS[k]] & ctl1[FLAG_POS[k]];
   end

   assign irq = |hot;
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
   import uart_rf_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int RX_W   = 9,
   parameter int RD_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              rx_valid,
   input  logic [RX_W-1:0]   rx_char,
   output logic              rx_ready,
   output logic              irq
);
   localparam int KEEP_W = (RX_W < RD_W) ? RX_W : RD_W;

   if (RD_W > REG_W || RD_W < 1) begin : g_rdw_chk
      $error("RD_W must lie in 1..REG_W");
   end
   if (RX_W < 1 || RX_W > REG_W) begin : g_rxw_chk
      $error("RX_W must lie in 1..REG_W");
   end

   logic [NREG-1:0] hit;
   logic [NREG-1:0] wr_hit, rd_hit;
   logic            rxf, txd, txe;
   logic            rx_take;
   logic [RX_W-1:0] data_q;
   logic [REG_W-1:0] ctl1_q;
   logic [REG_W-1:0] cfg_q [NCFG];
   logic [REG_W-1:0] stat_word;
   logic [REG_W-1:0] rd_mux;
   logic [REG_W-1:0] rdata_q;

   uart_rf_decode #(.ADDR_W(ADDR_W), .N(NREG)) u_dec (
      .sel  (bus_sel),
      .addr (bus_addr),
      .hit  (hit)
   );

   assign wr_hit  = hit & {NREG{bus_wr}};
   assign rd_hit  = hit & {NREG{~bus_wr}};
   assign rx_ready = ~rxf;
   assign rx_take  = rx_valid & rx_ready;

   uart_rf_status u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_wr (wr_hit[RI_STAT]),
      .wdata   (bus_wdata),
      .data_rd (rd_hit[RI_DATA]),
      .data_wr (wr_hit[RI_DATA]),
      .rx_take (rx_take),
      .rxf     (rxf),
      .txd     (txd),
      .txe     (txe)
   );

   always_comb begin
      stat_word          = '0;
      stat_word[BIT_RXF] = rxf;
      stat_word[BIT_TXD] = txd;
      stat_word[BIT_TXE] = txe;
   end

   uart_rf_irq u_irq (
      .stat (stat_word),
      .ctl1 (ctl1_q),
      .irq  (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         data_q <= '0;
      else if (rx_take)
         data_q <= rx_char;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl1_q <= '0;
      else if (wr_hit[RI_CTL1])
         ctl1_q <= bus_wdata;
   end

   for (genvar c = 0; c < NCFG; c++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_q[c] <= '0;
         else if (wr_hit[CFG_IDX[c]])
            cfg_q[c] <= bus_wdata;
      end
   end

   always_comb begin
      rd_mux = '0;
      if (rd_hit[RI_STAT]) rd_mux = stat_word;
      if (rd_hit[RI_DATA]) rd_mux[KEEP_W-1:0] = data_q[KEEP_W-1:0];
      if (rd_hit[RI_CTL1]) rd_mux = ctl1_q;
      for (int c = 0; c < NCFG; c++) begin
         if (rd_hit[CFG_IDX[c]]) rd_mux = cfg_q[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (bus_sel && !bus_wr)
         rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;

   // R3
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |=> $stable(data_q));

   // R2
   idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl1_q[BIT_TXE] |-> irq);

   // R10
   unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && hit == '0) |=> ($stable(ctl1_q) && $stable(cfg_q[0])
                                             && $stable(cfg_q[3])));

   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

// File: tb/test_uart_regfront.sv
module test_uart_regfront;
   localparam int ADDR_W = 5;
   localparam int RX_W   = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              rx_valid = 1'b0;
   logic [RX_W-1:0]   rx_char = '0;
   logic              rx_ready;
   logic              irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #2 clk = ~clk;

   uart_regfront #(.ADDR_W(ADDR_W), .RX_W(RX_W), .RD_W(10)) i_uart_regfront (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rx_valid  (rx_valid),
      .rx_char   (rx_char),
      .rx_ready  (rx_ready),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // monitor: pops expected read data the negedge after a read edge
   initial begin
      forever begin
         logic was_rd;
         @(posedge clk);
         was_rd = bus_sel && !bus_wr && rst_n;
         @(negedge clk);
         if (was_rd) begin
            if (exp_q.size() == 0) begin
               check("scoreboard underrun", 32'd1, 32'd0);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, bus_rdata, e);
            end
         end
      end
   end

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rx_send(input logic [RX_W-1:0] ch);
      rx_valid = 1'b1; rx_char = ch;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", {31'b0, irq}, 32'd0);
      check("R1 rx_ready", {31'b0, rx_ready}, 32'd1);
      bus_read(5'h00, 32'h0000_00C0, "R1 status");
      bus_read(5'h08, 32'h0, "R1 baud");
      bus_read(5'h0C, 32'h0, "R1 ctl1");
      bus_read(5'h18, 32'h0, "R1 guard");

      // R2 R7 enable transmit-done interrupt
      bus_write(5'h0C, 32'h0000_0040);
      check("R2 irq on txd enable", {31'b0, irq}, 32'd1);
      bus_read(5'h0C, 32'h0000_0040, "R7 ctl1");

      // R5 clear bit 6 by AND
      bus_write(5'h00, 32'hFFFF_FFBF);
      check("R5 irq after clear", {31'b0, irq}, 32'd0);
      bus_read(5'h00, 32'h0000_0080, "R5 status");

      // R6 data write sets bit 6
      bus_write(5'h04, 32'h0000_0055);
      check("R6 irq after data write", {31'b0, irq}, 32'd1);
      bus_read(5'h00, 32'h0000_00C0, "R6 status");

      // R5 zero write keeps bit 7
      bus_write(5'h00, 32'h0);
      bus_read(5'h00, 32'h0000_0080, "R5 txe kept");
      bus_write(5'h0C, 32'h0000_0020);
      check("R2 irq low no rxf", {31'b0, irq}, 32'd0);

      // R3 receive
      rx_send(9'h1A5);
      check("R3 rx_ready low", {31'b0, rx_ready}, 32'd0);
      check("R2 irq on rxf", {31'b0, irq}, 32'd1);
      bus_read(5'h00, 32'h0000_00A0, "R3 status");
      rx_send(9'h03C);
      // R4 read returns held value, not the ignored one
      bus_read(5'h04, 32'h0000_01A5, "R4 R3 data held");
      check("R4 rx_ready after read", {31'b0, rx_ready}, 32'd1);
      check("R4 irq after read", {31'b0, irq}, 32'd0);
      bus_read(5'h00, 32'h0000_0080, "R4 status");

      // R2 transmit-idle enable
      bus_write(5'h0C, 32'h0000_0080);
      check("R2 irq txe", {31'b0, irq}, 32'd1);
      bus_write(5'h0C, 32'h0);
      check("R2 irq off", {31'b0, irq}, 32'd0);

      // R8 config words
      bus_write(5'h08, 32'h1234_ABCD);
      bus_write(5'h10, 32'hFFFF_FFFF);
      bus_write(5'h14, 32'h0000_005A);
      bus_write(5'h18, 32'h0000_00C3);
      bus_read(5'h08, 32'h1234_ABCD, "R8 baud");
      bus_read(5'h10, 32'hFFFF_FFFF, "R8 ctl2");
      bus_read(5'h14, 32'h0000_005A, "R8 ctl3");
      bus_read(5'h18, 32'h0000_00C3, "R8 guard");

      // R10 unmapped
      bus_write(5'h1C, 32'hFFFF_FFFF);
      bus_read(5'h1C, 32'h0, "R10 unmapped read");
      bus_read(5'h0C, 32'h0, "R10 ctl1 untouched");
      // R11 hold
      repeat (2) @(negedge clk);
      check("R11 rdata held", bus_rdata, 32'h0);

      // R9 collision with status clear
      bus_write(5'h0C, 32'h0000_0020);
      rx_valid = 1'b1; rx_char = 9'h07E;
      bus_write(5'h00, 32'h0);
      rx_valid = 1'b0;
      check("R9 rx_ready", {31'b0, rx_ready}, 32'd0);
      check("R9 irq", {31'b0, irq}, 32'd1);
      bus_read(5'h00, 32'h0000_00A0, "R9 status after clear race");
      bus_read(5'h04, 32'h0000_007E, "R9 data after clear race");

      // R9 collision with data read
      rx_valid = 1'b1; rx_char = 9'h111;
      bus_read(5'h04, 32'h0000_007E, "R9 old data on race read");
      rx_valid = 1'b0;
      check("R9 rx_ready after read race", {31'b0, rx_ready}, 32'd0);
      bus_read(5'h00, 32'h0000_00A0, "R9 status after read race");
      bus_read(5'h04, 32'h0000_0111, "R9 new data");

      @(negedge clk);
      check("scoreboard drained", exp_q.size(), 32'd0);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            check("watchdog", 32'd1, 32'd0);
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule